// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline with Selectable Branch Delay

This block is the control core of a small instruction pipeline with three stages: fetch, decode and execute. It issues one fetch address per clock to a synchronous instruction memory that sits outside the block. The word read back enters decode and then execute. Once the pipe is full, one instruction completes per clock, and each instruction spends three cycles in flight. A one-register accumulator makes execution visible at the ports. The instruction set is deliberately tiny: no-op, add-immediate, load-immediate and branch.

Branches are resolved in the execute stage. Each branch word chooses its own behaviour through one bit. The delayed form lets the two words behind it finish and then continues at the target with no lost cycle. The non-delayed form discards those two words, refetches from the target and shows two empty execute cycles. A branch that lands in a delay slot of a delayed branch does nothing.

The memory is expected to register the word at `fetch_addr` on a rising edge whenever `fetch_en` is high, and to present it on `instr_in` in the following cycle.

Top module: `pipe3_branch_core`

## Requirements
- R1: While `rst` is high, `fetch_en`, `fetch_addr`, `exec_valid`, `squash` and `acc` all read zero.
- R2: After `rst` falls, `fetch_en` goes high on the first rising edge with `fetch_addr` = 0. The instruction at address 0 raises `exec_valid` from the third rising edge on. Without branches, one instruction executes per clock at consecutive addresses, each reported on `exec_pc`.
- R3: Encoding for IW=16: bits [15:14] are the operation (00 no-op, 01 add, 10 load, 11 branch). Add does `acc += imm` and load does `acc = imm`, where imm is bits [12:0] zero-extended. `acc` shows the result in the cycle after the instruction's `exec_valid` cycle.
- R4: A branch with bit 13 = 1 (delayed) is followed in the next two execute cycles by the words at its address +1 and +2. The target word executes in the cycle after those two, with no empty cycle. The target is bits [AW-1:0].
- R5: A branch with bit 13 = 0 (non-delayed) is followed by exactly two cycles with `exec_valid` low, after which the target executes. The two words behind the branch never change `acc`.
- R6: `squash` is high for exactly one cycle, namely the first empty execute cycle after a non-delayed branch. It is low at all other times.
- R7: A branch of either kind that executes in one of the two delay slots of a delayed branch acts as a no-op. It neither redirects fetch nor raises `squash`.
- R8: Fetch and execute addresses wrap modulo 2^AW, so address 2^AW-1 is followed by address 0.
- R9: Once `fetch_en` has risen it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | IW | Word returned by the instruction memory for the previous cycle's fetch address |
| fetch_en | output | 1 | Read enable for the instruction memory |
| fetch_addr | output | AW | Address to fetch |
| exec_valid | output | 1 | An instruction occupies the execute stage this cycle |
| exec_pc | output | AW | Address of the instruction in execute |
| squash | output | 1 | One-cycle pulse marking a flush by a non-delayed branch |
| acc | output | DW | Accumulator |

## Verification
The bench uses the default parameters: a 16-bit instruction word, an 8-bit address and a 16-bit accumulator. With an address space of only 256 words, a program placed at the top of memory crosses from 255 to 0 within a few cycles. The bench runs several short programs, and each is compared every cycle against a model that interprets the program one instruction at a time. The programs cover:
- chains of delayed branches whose slots contain further branches;
- a non-delayed branch to itself that flushes repeatedly;
- a delayed branch whose target is its own first slot;
- a loop that wraps past the last address.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  // Operation field, held in the two top bits of the instruction word.
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_ADD    = 2'd1,
    OP_LOAD   = 2'd2,
    OP_BRANCH = 2'd3
  } op_e;

  // Number of words behind a delayed branch that still execute.
  localparam int unsigned SLOT_COUNT = 2;

endpackage

// File: rtl/p3_fetch.sv
module p3_fetch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir,
  input  logic [AW-1:0] redir_tgt,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr
);

  // Program counter: enable turns on one edge after reset,
  // then the address advances every cycle unless redirected.
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_en   <= 1'b0;
      fetch_addr <= '0;
    end else if (redir) begin
      fetch_en   <= 1'b1;
      fetch_addr <= redir_tgt;
    end else if (fetch_en) begin
      fetch_addr <= fetch_addr + AW'(1);
    end else begin
      fetch_en   <= 1'b1;
    end
  end

  assert_fetch_stays_on_R9: assert property (
    @(posedge clk) disable iff (rst) fetch_en |=> fetch_en);

endmodule

// File: rtl/p3_decode.sv
module p3_decode #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          fetch_en,
  input  logic [AW-1:0] fetch_addr,
  output logic          d_valid,
  output logic [AW-1:0] d_pc
);

  // The memory's output register holds the decode-stage word.
  // This stage tracks whether that word is live and where it came from.
  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid <= 1'b0;
    end else begin
      d_valid <= fetch_en && !flush;
    end
    d_pc <= fetch_addr;
  end

  assert_flush_kills_decode_R5: assert property (
    @(posedge clk) disable iff (rst) flush |=> !d_valid);

endmodule

// File: rtl/p3_exec.sv
module p3_exec
  import pipe3_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          d_valid,
  input  logic [AW-1:0] d_pc,
  input  logic [IW-1:0] instr_in,
  output logic          redir,
  output logic          flush,
  output logic [AW-1:0] redir_tgt,
  output logic          ex_valid,
  output logic [AW-1:0] ex_pc,
  output logic          squash,
  output logic [DW-1:0] acc
);

  localparam int IMMW = IW - 3;
  localparam int SW   = $clog2(SLOT_COUNT + 1);

  logic [IW-1:0]   ex_instr;
  logic [SW-1:0]   slots;
  op_e             op;
  logic            is_delayed;
  logic [IMMW-1:0] imm;
  logic            take;

  always_comb begin
    op         = op_e'(ex_instr[IW-1 -: 2]);
    is_delayed = ex_instr[IW-3];
    imm        = ex_instr[IMMW-1:0];
    take       = ex_valid && (op == OP_BRANCH) && (slots == '0);
    redir      = take;
    flush      = take && !is_delayed;
    redir_tgt  = ex_instr[AW-1:0];
  end

  // Execute stage register
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      squash   <= 1'b0;
    end else begin
      ex_valid <= d_valid && !flush;
      squash   <= flush;
    end
    ex_instr <= instr_in;
    ex_pc    <= d_pc;
  end

  // Delay-slot counter: branches seen while it is non-zero are no-ops
  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
    end else if (take && is_delayed) begin
      slots <= SW'(SLOT_COUNT);
    end else if (ex_valid && (slots != '0)) begin
      slots <= slots - SW'(1);
    end
  end

  // Accumulator write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (ex_valid) begin
      unique case (op)
        OP_ADD:  acc <= acc + DW'(imm);
        OP_LOAD: acc <= DW'(imm);
        default: ;
      endcase
    end
  end

  // R2 and R4: absent a flush, the next execute slot holds the next address,
  // except after the last delay slot.
  assert_seq_flow_R2: assert property (
    @(posedge clk) disable iff (rst)
    (ex_valid && !flush && slots != SW'(1)) |=>
      (ex_valid && ex_pc == $past(ex_pc) + AW'(1)));

  assert_slot_no_bubble_R4: assert property (
    @(posedge clk) disable iff (rst)
    (ex_valid && slots == SW'(1)) |=> ex_valid);

  assert_slots_live_R7: assert property (
    @(posedge clk) disable iff (rst) (slots != '0) |-> ex_valid);

  assert_flush_bubble_R5: assert property (
    @(posedge clk) disable iff (rst) flush |=> (!ex_valid && squash));

  assert_squash_single_R6: assert property (
    @(posedge clk) disable iff (rst) squash |=> (!ex_valid && !squash));

  assert_acc_idle_R3: assert property (
    @(posedge clk) disable iff (rst) !ex_valid |=> $stable(acc));

endmodule

// File: rtl/pipe3_branch_core.sv
module pipe3_branch_core #(
  parameter int IW = 16,  // instruction width; AW must not exceed IW-3
  parameter int AW = 8,   // fetch address width
  parameter int DW = 16   // accumulator width
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr_in,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  output logic          exec_valid,
  output logic [AW-1:0] exec_pc,
  output logic          squash,
  output logic [DW-1:0] acc
);

  logic          redir;
  logic          flush;
  logic [AW-1:0] redir_tgt;
  logic          d_valid;
  logic [AW-1:0] d_pc;

  p3_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .redir      (redir),
    .redir_tgt  (redir_tgt),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr)
  );

  p3_decode #(.AW(AW)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr),
    .d_valid    (d_valid),
    .d_pc       (d_pc)
  );

  p3_exec #(.IW(IW), .AW(AW), .DW(DW)) u_exec (
    .clk       (clk),
    .rst       (rst),
    .d_valid   (d_valid),
    .d_pc      (d_pc),
    .instr_in  (instr_in),
    .redir     (redir),
    .flush     (flush),
    .redir_tgt (redir_tgt),
    .ex_valid  (exec_valid),
    .ex_pc     (exec_pc),
    .squash    (squash),
    .acc       (acc)
  );

endmodule

// File: tb/pipe3_branch_core_bench.sv
module pipe3_branch_core_bench;

  localparam int IW    = 16;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] instr_q = '0;
  logic          fetch_en;
  logic [AW-1:0] fetch_addr;
  logic          exec_valid;
  logic [AW-1:0] exec_pc;
  logic          squash;
  logic [DW-1:0] acc;

  logic [IW-1:0] mem [DEPTH];

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // Synchronous-read instruction memory
  always_ff @(posedge clk) begin
    if (fetch_en) instr_q <= mem[fetch_addr];
  end

  pipe3_branch_core #(.IW(IW), .AW(AW), .DW(DW)) u_pipe3_branch_core (
    .clk        (clk),
    .rst        (rst),
    .instr_in   (instr_q),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr),
    .exec_valid (exec_valid),
    .exec_pc    (exec_pc),
    .squash     (squash),
    .acc        (acc)
  );

  function automatic logic [IW-1:0] w_add(input int v);
    return {2'b01, 1'b0, 13'(v)};
  endfunction
  function automatic logic [IW-1:0] w_load(input int v);
    return {2'b10, 1'b0, 13'(v)};
  endfunction
  function automatic logic [IW-1:0] w_br(input bit dly, input int t);
    return {2'b11, dly, 5'd0, 8'(t)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  // Reset, then compare the core against an instruction-level model every cycle
  task automatic run_prog(input string tag, input int ncyc);
    int          m_pc = 0;
    logic [DW-1:0] m_acc = '0;
    int          bubbles = 0;
    int          slots = 0;
    int          pend = 0;
    bit          sq_next = 0;
    bit          e_valid;
    bit          e_sq;
    int          e_pc;
    logic [IW-1:0] w;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetch_en == 1'b0 && fetch_addr == '0, "R1 fetch reset", int'(fetch_addr), 0);
    check(exec_valid == 1'b0 && squash == 1'b0, "R1 strobe reset", int'(exec_valid), 0);
    check(acc == '0, "R1 acc reset", int'(acc), 0);
    rst = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1)
        check(fetch_en && fetch_addr == '0, {"R2 first fetch ", tag}, int'(fetch_addr), 0);
      check(fetch_en == 1'b1, {"R9 fetch enable ", tag}, int'(fetch_en), 1);
      e_pc = 0;
      if (c < 3) begin
        e_valid = 0;
        e_sq = 0;
      end else begin
        e_sq = sq_next;
        sq_next = 0;
        if (bubbles > 0) begin
          e_valid = 0;
          bubbles--;
        end else begin
          e_valid = 1;
          e_pc = m_pc;
        end
      end
      check(exec_valid == e_valid, {"R2 R5 exec_valid ", tag}, int'(exec_valid), int'(e_valid));
      if (e_valid)
        check(int'(exec_pc) == e_pc, {"R4 R5 R7 R8 exec_pc ", tag}, int'(exec_pc), e_pc);
      check(squash == e_sq, {"R6 squash ", tag}, int'(squash), int'(e_sq));
      check(acc == m_acc, {"R3 R5 acc ", tag}, int'(acc), int'(m_acc));
      if (e_valid) begin
        w = mem[m_pc];
        if (w[15:14] == 2'b01) m_acc = m_acc + DW'(w[12:0]);
        if (w[15:14] == 2'b10) m_acc = DW'(w[12:0]);
        if (slots > 0) begin
          slots--;
          m_pc = (slots == 0) ? pend : (m_pc + 1) % DEPTH;
        end else if (w[15:14] == 2'b11) begin
          if (w[13]) begin
            slots = 2;
            pend = int'(w[AW-1:0]);
            m_pc = (m_pc + 1) % DEPTH;
          end else begin
            m_pc = int'(w[AW-1:0]);
            bubbles = 2;
            sq_next = 1;
          end
        end else begin
          m_pc = (m_pc + 1) % DEPTH;
        end
      end
    end
  endtask

  initial begin
    // P1: straight line, delayed jump, non-delayed jump, branch in a slot
    clear_mem();
    mem[0]  = w_load(5);   mem[1]  = w_add(3);   mem[2]  = w_br(1, 10);
    mem[3]  = w_add(1);    mem[4]  = w_add(2);   mem[5]  = w_add(100);
    mem[10] = w_add(7);    mem[11] = w_br(0, 20); mem[12] = w_add(50);
    mem[13] = w_add(60);   mem[20] = w_add(1);   mem[21] = w_br(1, 0);
    mem[22] = w_br(0, 5);  mem[23] = w_add(2);
    run_prog("mixed R3 R4 R5 R7", 80);

    // P2: delayed branch whose slots both hold branches
    clear_mem();
    mem[0] = w_br(1, 8);   mem[1] = w_br(1, 30);  mem[2] = w_br(0, 40);
    mem[8] = w_add(1);     mem[9] = w_br(0, 0);   mem[30] = w_add(900);
    mem[40] = w_add(800);
    run_prog("slot branches R7", 60);

    // P3: non-delayed branch to itself, flushing over and over
    clear_mem();
    mem[0] = w_load(1);    mem[1] = w_br(0, 1);   mem[2] = w_add(9);
    mem[3] = w_add(9);
    run_prog("self loop R5 R6", 40);

    // P4: delayed branch targeting its own first slot
    clear_mem();
    mem[0] = w_load(0);    mem[1] = w_br(1, 2);   mem[2] = w_add(1);
    mem[3] = w_add(2);     mem[4] = w_br(1, 1);   mem[5] = w_add(4);
    mem[6] = w_add(8);
    run_prog("slot target R4", 60);

    // P5: wrap from the top of the address space
    clear_mem();
    mem[0] = w_br(0, 252); mem[252] = w_add(1);   mem[253] = w_add(2);
    mem[254] = w_br(1, 1); mem[255] = w_add(3);   mem[1] = w_add(4);
    mem[2] = w_br(0, 0);
    run_prog("wrap R8", 60);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule